// File: doc/BRIEF.md
# Row-Buffered DRAM Access Controller

This block sits between user logic and a wide synchronous DRAM core and makes the DRAM look like a pipelined SRAM. The user side presents a request strobe, a write enable, a word address and write data. Nothing about rows, columns or refresh reaches the user port. Internally the controller keeps a small set of row buffers. Each buffer holds one complete DRAM row of eight 128-bit words, and the buffers are indexed by a field of the address like a direct-mapped cache.

A request that finds its row in a buffer is a hit. A hit is accepted in the cycle it is presented. Read data comes back in request order with a valid flag, a fixed number of cycles later, and back-to-back hits stream at one per cycle. Writes update the buffer and are passed through to the DRAM as column writes in the same cycle.

Every hazard raises a stall in the cycle it is detected and holds it for a fixed number of cycles. The user keeps the request steady until the stall drops. The hazards are:
- a row miss, which fetches the whole row from the DRAM;
- a write that directly follows an accepted read;
- a clock-phase realignment request.

A host halt, used for refresh, freezes all user traffic and all DRAM commands for as long as it is high.

Top module: `rowbuf_dram_ctrl`

## Requirements
- R1: After reset the stall, read-valid and DRAM command outputs are low, every row buffer is invalid, and so the first access to any buffer is a miss.
- R2: A read hit accepted in cycle t (request high, stall low) drives read-valid high in cycle t+6 with the addressed word; read data returns in request order.
- R3: Consecutive hits with no idle cycle between them are each accepted without stall, one per cycle.
- R4: A miss holds stall high for exactly 10 consecutive cycles starting in the cycle the request is first presented; the held request is accepted in the 11th cycle.
- R5: During a miss the DRAM command port issues, one per cycle with no gaps while not halted: activate (code 1) for the new row in the detection cycle, then column reads (code 2) for columns 0 to 7 in ascending order, then precharge (code 4). It issues no-op (code 0) in every other stall cycle.
- R6: An accepted write stores its data in the row buffer and issues a column write (code 3) in the same cycle with the row, column and data of the request; a later read of that address returns the new data.
- R7: A write presented in the cycle right after an accepted read, to a buffered row, stalls for exactly 4 cycles and is then accepted.
- R8: A rising edge of the realign input while the controller is idle and not halted stalls for exactly 1 cycle, in which no request is accepted.
- R9: While host halt is high, stall is high, no request is accepted and the DRAM command is no-op; a miss in progress pauses and resumes its command sequence after the halt, lengthening the stall by the halt length.
- R10: Address bits [2:0] select the word, bits [4:3] select the row buffer and bits [8:5] are the row tag. A request to a buffer holding a different tag misses and replaces that buffer, while the other buffers keep their rows.
- R11: Stall depends on the request in the same cycle: a missing request sees stall high in the very cycle it is first presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usrReq | input | 1 | User request strobe, held while stalled |
| usrWe | input | 1 | 1 = write, 0 = read |
| usrAddr | input | 9 | Word address {tag, buffer index, word} |
| usrWdata | input | 128 | User write data |
| usrStall | output | 1 | Request not accepted this cycle |
| usrRvalid | output | 1 | Read data valid |
| usrRdata | output | 128 | Read data |
| hostHalt | input | 1 | Refresh halt from the host |
| clkRealign | input | 1 | Clock-phase realignment request (edge sensitive) |
| dramCmd | output | 3 | DRAM command: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge |
| dramRow | output | 6 | DRAM row of the command |
| dramCol | output | 3 | DRAM column of the command |
| dramWdata | output | 128 | DRAM write data |
| dramRdata | input | 128 | DRAM read data, one cycle after a read command |
| dramRvalid | input | 1 | DRAM read data valid |

## Verification
The bench goes after the stall lengths under each hazard: a controller that registered its hazard detection would stall one cycle late, and a wrong counter load would give 9 or 11 cycles instead of 10, each caught by cycle-exact stall counts. It interrupts a row fill with a halt, where a design that kept counting or issuing commands through the halt would misplace column reads or leave the buffer half filled, which the later read data exposes. Reads are issued right before writes to hit the read-to-write stall, and the bench reads back after both write hits and tag replacements to catch stale buffer contents.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [2:0] {
    DCMD_NOP = 3'd0,
    DCMD_ACT = 3'd1,
    DCMD_RD  = 3'd2,
    DCMD_WR  = 3'd3,
    DCMD_PRE = 3'd4
  } dramCmd_e;

  typedef struct packed {
    logic acceptRd;
    logic acceptWr;
    logic fillStart;
  } dpStrobe_t;

endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int WORD_BITS   = 3,
  parameter int MISS_STALL  = 10,
  parameter int WAR_STALL   = 4,
  parameter int ALIGN_STALL = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        usrReq,
  input  logic                        usrWe,
  input  logic [ADDR_W-1:0]           usrAddr,
  input  logic                        bufHit,
  input  logic                        hostHalt,
  input  logic                        clkRealign,
  output logic                        usrStall,
  output dpStrobe_t                   strobe,
  output logic [2:0]                  dramCmd,
  output logic [ADDR_W-WORD_BITS-1:0] dramRow,
  output logic [WORD_BITS-1:0]        dramCol
);

  localparam int ROW_W = ADDR_W - WORD_BITS;
  localparam int WORDS = 1 << WORD_BITS;
  localparam int CNT_W = $clog2(MISS_STALL + 1);
  localparam logic [CNT_W-1:0] MISS_LOAD  = CNT_W'(MISS_STALL - 1);
  localparam logic [CNT_W-1:0] WAR_LOAD   = CNT_W'(WAR_STALL - 1);
  localparam logic [CNT_W-1:0] ALIGN_LOAD = CNT_W'(ALIGN_STALL - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] WORDS_C    = CNT_W'(WORDS);

  logic [CNT_W-1:0] stallCnt;
  logic [CNT_W-1:0] stepVal;
  logic             missActive;
  logic             prevRd;
  logic             realignPrev;
  logic [ROW_W-1:0] fillRow;

  logic realignEdge, busy, free, probe;
  logic alignHaz, missHaz, warHaz, accept;
  dramCmd_e cmdSel;

  always_comb begin
    realignEdge = clkRealign & ~realignPrev;
    busy        = (stallCnt != '0);
    free        = ~hostHalt & ~busy;
    alignHaz    = free & realignEdge;
    probe       = free & ~realignEdge & usrReq;
    missHaz     = probe & ~bufHit;
    warHaz      = probe & bufHit & usrWe & prevRd;
    accept      = probe & bufHit & ~(usrWe & prevRd);
    usrStall    = hostHalt | busy | alignHaz | missHaz | warHaz;

    strobe.acceptRd  = accept & ~usrWe;
    strobe.acceptWr  = accept & usrWe;
    strobe.fillStart = missHaz;
  end

  // Fill schedule: step 0.. after the activate cycle, one column per step.
  always_comb begin
    stepVal = MISS_LOAD - stallCnt;
    cmdSel  = DCMD_NOP;
    dramRow = usrAddr[ADDR_W-1:WORD_BITS];
    dramCol = usrAddr[WORD_BITS-1:0];
    if (missHaz) begin
      cmdSel = DCMD_ACT;
    end else if (missActive && !hostHalt) begin
      dramRow = fillRow;
      dramCol = '0;
      if (stallCnt == CNT_ONE) begin
        cmdSel = DCMD_PRE;
      end else if (stepVal < WORDS_C) begin
        cmdSel  = DCMD_RD;
        dramCol = stepVal[WORD_BITS-1:0];
      end
    end else if (accept && usrWe) begin
      cmdSel = DCMD_WR;
    end
    dramCmd = cmdSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt    <= '0;
      missActive  <= 1'b0;
      prevRd      <= 1'b0;
      realignPrev <= 1'b0;
      fillRow     <= '0;
    end else begin
      realignPrev <= clkRealign;
      prevRd      <= accept & ~usrWe;
      if (missHaz) begin
        stallCnt   <= MISS_LOAD;
        missActive <= 1'b1;
        fillRow    <= usrAddr[ADDR_W-1:WORD_BITS];
      end else if (warHaz) begin
        stallCnt <= WAR_LOAD;
      end else if (alignHaz) begin
        stallCnt <= ALIGN_LOAD;
      end else if (busy && !hostHalt) begin
        stallCnt <= stallCnt - CNT_ONE;
        if (missActive && stallCnt == CNT_ONE) missActive <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rbc_datapath.sv
module rbc_datapath
  import rbc_pkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int TAG_BITS  = 4,
  parameter int IDX_BITS  = 2,
  parameter int WORD_BITS = 3,
  parameter int HIT_LAT   = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  dpStrobe_t                             strobe,
  input  logic [TAG_BITS+IDX_BITS+WORD_BITS-1:0] usrAddr,
  input  logic [DATA_W-1:0]                     usrWdata,
  input  logic [DATA_W-1:0]                     dramRdata,
  input  logic                                  dramRvalid,
  output logic                                  bufHit,
  output logic                                  rdValid,
  output logic [DATA_W-1:0]                     rdData
);

  localparam int NUM_BUF = 1 << IDX_BITS;
  localparam int WORDS   = 1 << WORD_BITS;

  logic [WORD_BITS-1:0] wordSel;
  logic [IDX_BITS-1:0]  idxSel;
  logic [TAG_BITS-1:0]  tagSel;

  assign wordSel = usrAddr[WORD_BITS-1:0];
  assign idxSel  = usrAddr[WORD_BITS +: IDX_BITS];
  assign tagSel  = usrAddr[WORD_BITS+IDX_BITS +: TAG_BITS];

  logic [TAG_BITS-1:0]  tagMem [NUM_BUF];
  logic [NUM_BUF-1:0]   validMem;
  logic [IDX_BITS-1:0]  fillIdx;
  logic [WORD_BITS-1:0] fillPtr;
  logic [DATA_W-1:0]    bankRd [NUM_BUF];

  assign bufHit = validMem[idxSel] && (tagMem[idxSel] == tagSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMem <= '0;
      fillIdx  <= '0;
      fillPtr  <= '0;
      for (int b = 0; b < NUM_BUF; b++) tagMem[b] <= '0;
    end else if (strobe.fillStart) begin
      validMem[idxSel] <= 1'b1;
      tagMem[idxSel]   <= tagSel;
      fillIdx          <= idxSel;
      fillPtr          <= '0;
    end else if (dramRvalid) begin
      fillPtr <= fillPtr + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_bank
    logic [DATA_W-1:0] words [WORDS];
    logic              fillHere, userHere;

    assign fillHere = dramRvalid && (fillIdx == IDX_BITS'(b));
    assign userHere = strobe.acceptWr && (idxSel == IDX_BITS'(b));

    always_ff @(posedge clk) begin
      if (fillHere) begin
        words[fillPtr] <= dramRdata;
      end else if (userHere) begin
        words[wordSel] <= usrWdata;
      end
    end

    assign bankRd[b] = words[wordSel];
  end

  // Read pipeline: data is captured at acceptance and delayed HIT_LAT cycles.
  logic              pipeV [HIT_LAT];
  logic [DATA_W-1:0] pipeD [HIT_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < HIT_LAT; s++) pipeV[s] <= 1'b0;
    end else begin
      pipeV[0] <= strobe.acceptRd;
      for (int s = 1; s < HIT_LAT; s++) pipeV[s] <= pipeV[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pipeD[0] <= bankRd[idxSel];
    for (int s = 1; s < HIT_LAT; s++) pipeD[s] <= pipeD[s-1];
  end

  assign rdValid = pipeV[HIT_LAT-1];
  assign rdData  = pipeD[HIT_LAT-1];

endmodule

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl
  import rbc_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int TAG_BITS    = 4,
  parameter int IDX_BITS    = 2,
  parameter int WORD_BITS   = 3,
  parameter int HIT_LAT     = 6,
  parameter int MISS_STALL  = 10,
  parameter int WAR_STALL   = 4,
  parameter int ALIGN_STALL = 1,
  localparam int ADDR_W     = TAG_BITS + IDX_BITS + WORD_BITS,
  localparam int ROW_W      = TAG_BITS + IDX_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usrReq,
  input  logic                 usrWe,
  input  logic [ADDR_W-1:0]    usrAddr,
  input  logic [DATA_W-1:0]    usrWdata,
  output logic                 usrStall,
  output logic                 usrRvalid,
  output logic [DATA_W-1:0]    usrRdata,
  input  logic                 hostHalt,
  input  logic                 clkRealign,
  output logic [2:0]           dramCmd,
  output logic [ROW_W-1:0]     dramRow,
  output logic [WORD_BITS-1:0] dramCol,
  output logic [DATA_W-1:0]    dramWdata,
  input  logic [DATA_W-1:0]    dramRdata,
  input  logic                 dramRvalid
);

  dpStrobe_t strobe;
  logic      bufHit;

  rbc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS), .MISS_STALL(MISS_STALL),
    .WAR_STALL(WAR_STALL), .ALIGN_STALL(ALIGN_STALL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrAddr(usrAddr),
    .bufHit(bufHit), .hostHalt(hostHalt), .clkRealign(clkRealign),
    .usrStall(usrStall), .strobe(strobe),
    .dramCmd(dramCmd), .dramRow(dramRow), .dramCol(dramCol)
  );

  rbc_datapath #(
    .DATA_W(DATA_W), .TAG_BITS(TAG_BITS), .IDX_BITS(IDX_BITS),
    .WORD_BITS(WORD_BITS), .HIT_LAT(HIT_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .usrAddr(usrAddr), .usrWdata(usrWdata),
    .dramRdata(dramRdata), .dramRvalid(dramRvalid),
    .bufHit(bufHit), .rdValid(usrRvalid), .rdData(usrRdata)
  );

  assign dramWdata = usrWdata;

endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int WORD_BITS = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 usrReq,
  input logic                 usrWe,
  input logic                 usrStall,
  input logic                 usrRvalid,
  input logic                 hostHalt,
  input logic                 clkRealign,
  input logic [2:0]           dramCmd,
  input logic [WORD_BITS-1:0] dramCol
);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostHalt |-> dramCmd == 3'd0);

  assert_halt_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostHalt |-> usrStall);

  assert_act_then_col0_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dramCmd == 3'd1) ##1 !hostHalt |-> (dramCmd == 3'd2) && (dramCol == '0));

  assert_write_only_on_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dramCmd == 3'd3) |-> usrReq && usrWe && !usrStall);

  assert_realign_stalls_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRealign) |-> usrStall);

  // Hit latency of 6 cycles (default pipeline depth).
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    usrRvalid |-> $past(usrReq && !usrWe && !usrStall, 6));

endmodule

bind rowbuf_dram_ctrl rbc_checker #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrStall(usrStall),
  .usrRvalid(usrRvalid), .hostHalt(hostHalt), .clkRealign(clkRealign),
  .dramCmd(dramCmd), .dramCol(dramCol)
);

// File: tb/sim_rowbuf_dram_ctrl.sv
`timescale 1ns/1ps
module sim_rowbuf_dram_ctrl;

  localparam int DW = 128;
  localparam int AW = 9;
  localparam int MISS = 10;
  localparam int WAR  = 4;
  localparam int LAT  = 6;

  logic clk = 1'b0;
  logic rstN;
  logic usrReq, usrWe, hostHalt, clkRealign;
  logic [AW-1:0] usrAddr;
  logic [DW-1:0] usrWdata;
  logic usrStall, usrRvalid;
  logic [DW-1:0] usrRdata;
  logic [2:0] dramCmd;
  logic [5:0] dramRow;
  logic [2:0] dramCol;
  logic [DW-1:0] dramWdata, dramRdata;
  logic dramRvalid;

  always #4 clk = ~clk;

  rowbuf_dram_ctrl u0 (
    .clk(clk), .rstN(rstN), .usrReq(usrReq), .usrWe(usrWe), .usrAddr(usrAddr),
    .usrWdata(usrWdata), .usrStall(usrStall), .usrRvalid(usrRvalid), .usrRdata(usrRdata),
    .hostHalt(hostHalt), .clkRealign(clkRealign), .dramCmd(dramCmd), .dramRow(dramRow),
    .dramCol(dramCol), .dramWdata(dramWdata), .dramRdata(dramRdata), .dramRvalid(dramRvalid)
  );

  function automatic logic [DW-1:0] initWord(int a);
    logic [31:0] s;
    s = 32'(a) * 32'h9E37_79B1 ^ 32'hC3A5_0000;
    return {s, ~s, s ^ 32'h1234_5678, s + 32'd77};
  endfunction

  // DRAM environment: row/column memory, read data one cycle after the command.
  logic [DW-1:0] dmem [512];
  always @(posedge clk) begin
    dramRvalid <= 1'b0;
    if (dramCmd == 3'd2) begin
      dramRdata  <= dmem[{dramRow, dramCol}];
      dramRvalid <= 1'b1;
    end
    if (dramCmd == 3'd3) dmem[{dramRow, dramCol}] <= dramWdata;
  end

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench expectation state
  logic [DW-1:0] shadow [512];
  bit   sValid [4];
  int   sTag [4];
  bit   lastRd;
  logic [DW-1:0] expQ [$];
  int   expCycQ [$];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read-return monitor (R2 latency and data, in-order return)
  always @(negedge clk) begin
    if (rstN) begin
      if (expCycQ.size() > 0 && expCycQ[0] + LAT == cyc) begin
        chk(usrRvalid && usrRdata == expQ[0], "R2", usrRvalid ? usrRdata : '0, expQ[0]);
        void'(expQ.pop_front());
        void'(expCycQ.pop_front());
      end else if (usrRvalid) begin
        chk(1'b0, "R2", 1, 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      usrReq = 1'b0; usrWe = 1'b0; hostHalt = 1'b0; clkRealign = 1'b0;
      lastRd = 1'b0;
    end
  endtask

  task automatic doAccess(input bit we, input int addr, input logic [DW-1:0] wd,
                          input int haltAt, input int haltLen, input bit realign,
                          output int stallSeen);
    int idx, tag, row, word, expStall, step, k;
    bit miss, war, firstStall;
    string tagS;
    idx  = (addr >> 3) & 3;
    tag  = (addr >> 5) & 15;
    row  = addr >> 3;
    word = addr & 7;
    miss = !sValid[idx] || sTag[idx] != tag;
    war  = !miss && we && lastRd && haltLen == 0 && !realign;
    expStall = (realign ? 1 : 0) + haltLen + (miss ? MISS : (war ? WAR : 0));
    tagS = realign ? "R8" : (haltLen > 0 ? "R9" : (miss ? "R4" : (war ? "R7" : "R3")));
    step = 0;
    k = 0;
    firstStall = 1'b0;
    forever begin
      @(negedge clk);
      usrReq = 1'b1; usrWe = we; usrAddr = AW'(addr); usrWdata = wd;
      hostHalt = (haltLen > 0 && k >= haltAt && k < haltAt + haltLen);
      clkRealign = realign && k == 0;
      #1;
      if (k == 0) firstStall = usrStall;
      if (!usrStall) break;
      if (hostHalt) begin
        chk(dramCmd == 3'd0, "R9", dramCmd, 0);
      end else if (realign && k == 0) begin
        chk(dramCmd == 3'd0, "R8", dramCmd, 0);
      end else if (miss) begin
        if (step == 0)
          chk(dramCmd == 3'd1 && dramRow == 6'(row), "R5", {dramCmd, dramRow}, {3'd1, 6'(row)});
        else if (step <= 8)
          chk(dramCmd == 3'd2 && dramRow == 6'(row) && dramCol == 3'(step - 1), "R5",
              {dramCmd, dramRow, dramCol}, {3'd2, 6'(row), 3'(step - 1)});
        else
          chk(dramCmd == 3'd4, "R5", dramCmd, 4);
        step++;
      end else begin
        chk(dramCmd == 3'd0, "R7", dramCmd, 0);
      end
      k++;
      if (k > 200) begin
        chk(1'b0, "R4", k, expStall);
        break;
      end
    end
    stallSeen = k;
    chk(k == expStall, tagS, k, expStall);
    if (miss && !realign && haltLen == 0) chk(firstStall, "R11", firstStall, 1);
    if (we)
      chk(dramCmd == 3'd3 && dramRow == 6'(row) && dramCol == 3'(word) && dramWdata == wd, "R6",
          {dramCmd, dramRow, dramCol}, {3'd3, 6'(row), 3'(word)});
    else
      chk(dramCmd == 3'd0, "R6", dramCmd, 0);
    if (miss) begin sValid[idx] = 1'b1; sTag[idx] = tag; end
    if (we) shadow[addr] = wd;
    else begin expQ.push_back(shadow[addr]); expCycQ.push_back(cyc); end
    lastRd = !we;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int s;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) begin dmem[i] = initWord(i); shadow[i] = initWord(i); end
    for (int i = 0; i < 4; i++) begin sValid[i] = 1'b0; sTag[i] = 0; end
    lastRd = 1'b0;
    rstN = 1'b0; usrReq = 1'b0; usrWe = 1'b0; usrAddr = '0; usrWdata = '0;
    hostHalt = 1'b0; clkRealign = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!usrStall, "R1", usrStall, 0);
    chk(!usrRvalid, "R1", usrRvalid, 0);
    chk(dramCmd == 3'd0, "R1", dramCmd, 0);

    // First access to a buffer misses after reset
    doAccess(1'b0, 9'h000, '0, 0, 0, 1'b0, s);
    chk(s == MISS, "R1", s, MISS);
    // Stream the rest of the row as back-to-back hits
    for (int w = 1; w < 8; w++) begin
      doAccess(1'b0, w, '0, 0, 0, 1'b0, s);
      chk(s == 0, "R3", s, 0);
    end
    // Write right after a read, then read it back
    doAccess(1'b1, 9'h003, {4{32'hDEAD_BEEF}}, 0, 0, 1'b0, s);
    chk(s == WAR, "R7", s, WAR);
    doAccess(1'b0, 9'h003, '0, 0, 0, 1'b0, s);
    doAccess(1'b1, 9'h004, {4{32'h0BAD_F00D}}, 0, 0, 1'b0, s);
    doAccess(1'b1, 9'h005, {4{32'h1357_9BDF}}, 0, 0, 1'b0, s);
    chk(s == 0, "R6", s, 0);
    idle(1);
    doAccess(1'b0, 9'h005, '0, 0, 0, 1'b0, s);

    // Address fields: same buffer index, other tag replaces; other buffers keep rows
    doAccess(1'b0, 9'h008, '0, 0, 0, 1'b0, s);   // buffer 1, tag 0
    doAccess(1'b0, 9'h02A, '0, 0, 0, 1'b0, s);   // buffer 1, tag 1
    chk(s == MISS, "R10", s, MISS);
    doAccess(1'b0, 9'h00B, '0, 0, 0, 1'b0, s);   // buffer 1, tag 0 again
    chk(s == MISS, "R10", s, MISS);
    doAccess(1'b0, 9'h006, '0, 0, 0, 1'b0, s);   // buffer 0 still held
    chk(s == 0, "R10", s, 0);

    // Realign edge
    idle(2);
    doAccess(1'b0, 9'h001, '0, 0, 0, 1'b1, s);
    chk(s == 1, "R8", s, 1);

    // Halt in the middle of a miss fill, then before a hit
    idle(1);
    doAccess(1'b0, 9'h1F7, '0, 3, 5, 1'b0, s);
    chk(s == MISS + 5, "R9", s, MISS + 5);
    doAccess(1'b0, 9'h1F0, '0, 0, 3, 1'b0, s);
    chk(s == 3, "R9", s, 3);
    doAccess(1'b1, 9'h1F1, {4{32'hCAFE_0001}}, 0, 2, 1'b0, s);
    doAccess(1'b0, 9'h1F1, '0, 0, 0, 1'b0, s);

    // Constrained random traffic over a few tags
    for (int n = 0; n < 400; n++) begin
      int a;
      bit w;
      a = int'($urandom_range(0, 127));
      w = ($urandom_range(0, 3) == 0);
      doAccess(w, a, {$urandom, $urandom, $urandom, $urandom}, 0, 0, 1'b0, s);
      if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)));
    end

    idle(LAT + 4);
    chk(expQ.size() == 0, "R2", expQ.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule